// File: doc/BRIEF.md
# Serial Port Register Front End with Internal Loopback

This block sits between a processor bus and the rest of a serial port. It decodes a 3-bit register offset that arrives with single-cycle read and write strobes. It keeps the line-format, interrupt-enable, modem-control and baud-divisor registers. It also passes bytes between the bus and the transmit and receive paths. One bit of the line-format register switches the two lowest offsets away from the data and interrupt-enable registers. With that bit set, the same offsets reach the two bytes of the baud divisor.

The modem-control register drives the RTS and DTR pins, which are active low. It also gates the serial interrupt onto its output pin. It can place the port in internal loopback. In loopback the transmitter's serial stream goes straight to the receiver, and the RTS and DTR bits take the place of the CTS and DSR inputs. The external serial output then rests at the idle high level, and both modem output pins stay inactive.

Each bus access is handled by a three-state access machine:
- ACC_IDLE waits for a strobe. It takes transition T_WR to ACC_WRITE when `wr_en` is high, or transition T_RD to ACC_READ when only `rd_en` is high.
- ACC_WRITE commits the captured byte.
- ACC_READ loads the read-data register.
- Both busy states return to ACC_IDLE by transition T_DONE after one cycle.

Top module: `uart_regfront`

## Requirements
- R1: After reset the line-format, modem-control, interrupt-enable and divisor registers are all zero. `rts_n` and `dtr_n` are 1, and `ser_out` follows `tx_serial`.
- R2: A strobe is captured on the first clock edge, and the access completes on the second edge. A written value is visible in registers and outputs after the second edge, and `rdata` holds the read value from the second edge until the next read. A strobe that arrives while an access is in progress is ignored. When `wr_en` and `rd_en` are high together, the write is performed.
- R3: With `line_fmt[7]` = 0, a write to offset 0 pulses `tx_load` high for exactly one cycle with `tx_data` equal to the written byte. A read of offset 0 returns `rx_data` and pulses `rx_pop` for exactly one cycle. Both pulses fall between the first and second edge.
- R4: With `line_fmt[7]` = 0, offset 1 is the interrupt-enable register. Bits 3:0 are stored and appear on `ier`, and bits 7:4 read as 0.
- R5: With `line_fmt[7]` = 1, offset 0 reads and writes `divisor[7:0]` and offset 1 reads and writes `divisor[15:8]`. These accesses produce no `tx_load` or `rx_pop` pulse and leave the interrupt-enable register unchanged.
- R6: Offset 3 is the line-format register. All 8 bits are readable and writable and drive `line_fmt`.
- R7: Offset 4 is the modem-control register. Bit 4 is loopback, bit 3 is the interrupt gate, bit 1 is RTS and bit 0 is DTR. Bits 7:5 and bit 2 are not stored and read as 0.
- R8: Outside loopback, `rts_n` is the inverse of modem-control bit 1 and `dtr_n` is the inverse of bit 0.
- R9: `irq_out` equals `irq_in` AND modem-control bit 3.
- R10: A read of offset 6 returns CTS in bit 4 and DSR in bit 5, with all other bits 0. Outside loopback, CTS is the inverse of `cts_n` and DSR is the inverse of `dsr_n`.
- R11: In loopback, `ser_out` is 1 and `rx_serial` follows `tx_serial`, whatever `ser_in` does. `rts_n` and `dtr_n` are 1, and the status read at offset 6 shows CTS equal to the RTS bit and DSR equal to the DTR bit.
- R12: Outside loopback, `line_fmt[6]` = 1 drives `ser_out` to 0. Otherwise `ser_out` equals `tx_serial`, and `rx_serial` equals `ser_in`.
- R13: Offsets 2, 5 and 7 read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Head byte of the receive path |
| rx_pop | output | 1 | One-cycle pulse when the receive byte is read |
| tx_data | output | 8 | Byte for the transmit path |
| tx_load | output | 1 | One-cycle pulse when a transmit byte is written |
| line_fmt | output | 8 | Line-format register contents |
| divisor | output | 16 | Baud divisor |
| ier | output | 4 | Interrupt-enable bits |
| tx_serial | input | 1 | Serial stream from the transmitter |
| rx_serial | output | 1 | Serial stream to the receiver |
| ser_out | output | 1 | External serial output pin |
| ser_in | input | 1 | External serial input pin |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| irq_in | input | 1 | Serial interrupt request from the interrupt logic |
| irq_out | output | 1 | Gated interrupt pin |

## Verification
The bench drives each strobe for one cycle from a falling edge.

The `tx_load` and `rx_pop` pulses are due in the cycle after the capturing edge. The bench therefore samples them at the next falling edge and again one cycle later to confirm the pulse has ended. Register values, `rdata` and everything decoded from the registers are due after the second rising edge, so they are sampled at the falling edge after it.

The pin-level paths for loopback, break, interrupt gating and modem status are combinational from stored bits and input pins. They are checked half a cycle after the input pin changes or the register write completes.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int IER_W     = 4;
    localparam int DIV_BYTES = 2;
    localparam int DIV_W     = DIV_BYTES * DATA_W;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IER   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_LINE  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MODEM = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_MSTAT = 3'd6;

    localparam int LINE_BANK_BIT  = 7;
    localparam int LINE_BREAK_BIT = 6;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic loop;
        logic irq_gate;
        logic rts;
        logic dtr;
    } modem_ctl_t;

endpackage

// File: rtl/uart_rf_access.sv
module uart_rf_access
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_data,
    output logic              do_wr,
    output logic              do_rd
);

    acc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_addr <= '0;
            acc_data <= '0;
        end else if (state_q == ACC_IDLE && (wr_en || rd_en)) begin
            acc_addr <= addr;
            acc_data <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (wr_en) begin
                    state_d = ACC_WRITE;
                end else if (rd_en) begin
                    state_d = ACC_READ;
                end
            end
            ACC_WRITE: state_d = ACC_IDLE;
            ACC_READ:  state_d = ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    always_comb begin
        do_wr = 1'b0;
        do_rd = 1'b0;
        unique case (state_q)
            ACC_IDLE:  ;
            ACC_WRITE: do_wr = 1'b1;
            ACC_READ:  do_rd = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/uart_rf_regs.sv
module uart_rf_regs
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_wr,
    input  logic              do_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              cts_eff,
    input  logic              dsr_eff,
    output logic [DATA_W-1:0] rdata,
    output logic              rx_pop,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] line_fmt,
    output logic [DIV_W-1:0]  divisor,
    output logic [IER_W-1:0]  ier,
    output modem_ctl_t        mctl
);

    logic                     bank_div;
    logic [DATA_W-1:0]        div_byte [DIV_BYTES];
    logic [DATA_W-1:0]        rd_mux;

    assign bank_div = line_fmt[LINE_BANK_BIT];
    assign tx_data  = acc_data;
    assign tx_load  = do_wr && !bank_div && (acc_addr == OFS_DATA);
    assign rx_pop   = do_rd && !bank_div && (acc_addr == OFS_DATA);

    for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                div_byte[b] <= '0;
            end else if (do_wr && bank_div && acc_addr == ADDR_W'(b)) begin
                div_byte[b] <= acc_data;
            end
        end
        assign divisor[b*DATA_W +: DATA_W] = div_byte[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_fmt <= '0;
            ier      <= '0;
            mctl     <= '0;
        end else if (do_wr) begin
            unique case (acc_addr)
                OFS_IER: begin
                    if (!bank_div) begin
                        ier <= acc_data[IER_W-1:0];
                    end
                end
                OFS_LINE: line_fmt <= acc_data;
                OFS_MODEM: begin
                    mctl.loop     <= acc_data[4];
                    mctl.irq_gate <= acc_data[3];
                    mctl.rts      <= acc_data[1];
                    mctl.dtr      <= acc_data[0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (acc_addr)
            OFS_DATA:  rd_mux = bank_div ? div_byte[0] : rx_data;
            OFS_IER:   rd_mux = bank_div ? div_byte[1]
                                         : {{(DATA_W-IER_W){1'b0}}, ier};
            OFS_LINE:  rd_mux = line_fmt;
            OFS_MODEM: rd_mux = {3'b000, mctl.loop, mctl.irq_gate, 1'b0,
                                 mctl.rts, mctl.dtr};
            OFS_MSTAT: rd_mux = {2'b00, dsr_eff, cts_eff, 4'b0000};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (do_rd) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/uart_rf_loop.sv
module uart_rf_loop
    import uart_rf_pkg::*;
(
    input  modem_ctl_t mctl,
    input  logic       brk,
    input  logic       tx_serial,
    input  logic       ser_in,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       irq_in,
    output logic       ser_out,
    output logic       rx_serial,
    output logic       rts_n,
    output logic       dtr_n,
    output logic       cts_eff,
    output logic       dsr_eff,
    output logic       irq_out
);

    always_comb begin
        if (mctl.loop) begin
            ser_out   = 1'b1;
            rx_serial = tx_serial;
            rts_n     = 1'b1;
            dtr_n     = 1'b1;
            cts_eff   = mctl.rts;
            dsr_eff   = mctl.dtr;
        end else begin
            ser_out   = brk ? 1'b0 : tx_serial;
            rx_serial = ser_in;
            rts_n     = !mctl.rts;
            dtr_n     = !mctl.dtr;
            cts_eff   = !cts_n;
            dsr_eff   = !dsr_n;
        end
    end

    assign irq_out = irq_in && mctl.irq_gate;

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_pop,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_load,
    output logic [DATA_W-1:0] line_fmt,
    output logic [DIV_W-1:0]  divisor,
    output logic [IER_W-1:0]  ier,
    input  logic              tx_serial,
    output logic              rx_serial,
    output logic              ser_out,
    input  logic              ser_in,
    output logic              rts_n,
    output logic              dtr_n,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              irq_in,
    output logic              irq_out
);

    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_data;
    logic              do_wr;
    logic              do_rd;
    logic              cts_eff;
    logic              dsr_eff;
    modem_ctl_t        mctl;

    uart_rf_access u_access (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .acc_addr (acc_addr),
        .acc_data (acc_data),
        .do_wr    (do_wr),
        .do_rd    (do_rd)
    );

    uart_rf_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_wr    (do_wr),
        .do_rd    (do_rd),
        .acc_addr (acc_addr),
        .acc_data (acc_data),
        .rx_data  (rx_data),
        .cts_eff  (cts_eff),
        .dsr_eff  (dsr_eff),
        .rdata    (rdata),
        .rx_pop   (rx_pop),
        .tx_load  (tx_load),
        .tx_data  (tx_data),
        .line_fmt (line_fmt),
        .divisor  (divisor),
        .ier      (ier),
        .mctl     (mctl)
    );

    uart_rf_loop u_loop (
        .mctl      (mctl),
        .brk       (line_fmt[LINE_BREAK_BIT]),
        .tx_serial (tx_serial),
        .ser_in    (ser_in),
        .cts_n     (cts_n),
        .dsr_n     (dsr_n),
        .irq_in    (irq_in),
        .ser_out   (ser_out),
        .rx_serial (rx_serial),
        .rts_n     (rts_n),
        .dtr_n     (dtr_n),
        .cts_eff   (cts_eff),
        .dsr_eff   (dsr_eff),
        .irq_out   (irq_out)
    );

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
    import uart_rf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              tx_load,
    input logic              rx_pop,
    input logic [DATA_W-1:0] line_fmt,
    input logic              ser_out,
    input logic              rts_n,
    input logic              dtr_n,
    input logic              irq_in,
    input logic              irq_out,
    input modem_ctl_t        mctl
);

    // R3
    tx_load_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> ($past(wr_en) && $past(addr) == OFS_DATA));

    // R3
    rx_pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> !rx_pop);

    // R5
    bank_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_fmt[LINE_BANK_BIT] |-> (!tx_load && !rx_pop));

    // R11
    loop_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mctl.loop |-> (ser_out && rts_n && dtr_n));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> irq_in);

endmodule

bind uart_regfront uart_regfront_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .tx_load  (tx_load),
    .rx_pop   (rx_pop),
    .line_fmt (line_fmt),
    .ser_out  (ser_out),
    .rts_n    (rts_n),
    .dtr_n    (dtr_n),
    .irq_in   (irq_in),
    .irq_out  (irq_out),
    .mctl     (mctl)
);

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  rx_data = '0;
    logic        rx_pop;
    logic [7:0]  tx_data;
    logic        tx_load;
    logic [7:0]  line_fmt;
    logic [15:0] divisor;
    logic [3:0]  ier;
    logic        tx_serial = 1'b1;
    logic        rx_serial;
    logic        ser_out;
    logic        ser_in = 1'b1;
    logic        rts_n;
    logic        dtr_n;
    logic        cts_n = 1'b1;
    logic        dsr_n = 1'b1;
    logic        irq_in = 1'b0;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_data(tx_data), .tx_load(tx_load), .line_fmt(line_fmt),
        .divisor(divisor), .ier(ier), .tx_serial(tx_serial),
        .rx_serial(rx_serial), .ser_out(ser_out), .ser_in(ser_in),
        .rts_n(rts_n), .dtr_n(dtr_n), .cts_n(cts_n), .dsr_n(dsr_n),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 rts_n", rts_n, 1);
        chk("R1 dtr_n", dtr_n, 1);
        chk("R1 divisor", divisor, 0);
        chk("R1 ier", ier, 0);
        chk("R1 line_fmt", line_fmt, 0);
        read_reg(3'd4, v);
        chk("R1 modem ctl", v, 0);
        tx_serial = 1'b0; #1;
        chk("R1 ser_out follows", ser_out, 0);
        tx_serial = 1'b1; #1;
        chk("R1 ser_out follows", ser_out, 1);
    endtask

    task automatic t_data();
        @(negedge clk);
        addr = 3'd0; wdata = 8'hA5; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 tx_load pulse", tx_load, 1);
        chk("R3 tx_data", tx_data, 8'hA5);
        chk("R3 rx_pop on write", rx_pop, 0);
        @(negedge clk);
        chk("R3 tx_load ends", tx_load, 0);
        rx_data = 8'h3C;
        @(negedge clk);
        addr = 3'd0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R3 rx_pop pulse", rx_pop, 1);
        chk("R3 tx_load on read", tx_load, 0);
        @(negedge clk);
        chk("R3 rx_pop ends", rx_pop, 0);
        chk("R3 rdata", rdata, 8'h3C);
    endtask

    task automatic t_ier();
        logic [7:0] v;
        write_reg(3'd1, 8'hFF);
        chk("R4 ier out", ier, 4'hF);
        read_reg(3'd1, v);
        chk("R4 ier readback", v, 8'h0F);
    endtask

    task automatic t_bank();
        logic [7:0] v;
        write_reg(3'd3, 8'h80);
        @(negedge clk);
        addr = 3'd0; wdata = 8'h34; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5 no tx_load", tx_load, 0);
        @(negedge clk);
        write_reg(3'd1, 8'h12);
        chk("R5 divisor", divisor, 16'h1234);
        chk("R5 ier untouched", ier, 4'hF);
        @(negedge clk);
        addr = 3'd0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R5 no rx_pop", rx_pop, 0);
        @(negedge clk);
        chk("R5 div low read", rdata, 8'h34);
        read_reg(3'd1, v);
        chk("R5 div high read", v, 8'h12);
        write_reg(3'd3, 8'h03);
        read_reg(3'd1, v);
        chk("R5 bank back to ier", v, 8'h0F);
    endtask

    task automatic t_line();
        logic [7:0] v;
        write_reg(3'd3, 8'h5B);
        chk("R6 line_fmt", line_fmt, 8'h5B);
        read_reg(3'd3, v);
        chk("R6 readback", v, 8'h5B);
        write_reg(3'd3, 8'h00);
    endtask

    task automatic t_modem();
        logic [7:0] v;
        write_reg(3'd4, 8'hFF);
        read_reg(3'd4, v);
        chk("R7 reserved read 0", v, 8'h1B);
        write_reg(3'd4, 8'h03);
        chk("R8 rts_n", rts_n, 0);
        chk("R8 dtr_n", dtr_n, 0);
        write_reg(3'd4, 8'h02);
        chk("R8 rts_n only", rts_n, 0);
        chk("R8 dtr_n idle", dtr_n, 1);
        write_reg(3'd4, 8'h01);
        chk("R8 rts_n idle", rts_n, 1);
        chk("R8 dtr_n only", dtr_n, 0);
    endtask

    task automatic t_irq();
        write_reg(3'd4, 8'h00);
        irq_in = 1'b1; #1;
        chk("R9 gated off", irq_out, 0);
        write_reg(3'd4, 8'h08);
        chk("R9 gated on", irq_out, 1);
        irq_in = 1'b0; #1;
        chk("R9 follows irq_in", irq_out, 0);
        write_reg(3'd4, 8'h00);
    endtask

    task automatic t_mstat();
        logic [7:0] v;
        cts_n = 1'b0; dsr_n = 1'b1;
        read_reg(3'd6, v);
        chk("R10 cts", v, 8'h10);
        cts_n = 1'b1; dsr_n = 1'b0;
        read_reg(3'd6, v);
        chk("R10 dsr", v, 8'h20);
        dsr_n = 1'b1;
    endtask

    task automatic t_loop();
        logic [7:0] v;
        write_reg(3'd4, 8'h12);
        tx_serial = 1'b0; ser_in = 1'b1; #1;
        chk("R11 ser_out idle", ser_out, 1);
        chk("R11 rx from tx", rx_serial, 0);
        ser_in = 1'b0; tx_serial = 1'b1; #1;
        chk("R11 ser_in ignored", rx_serial, 1);
        chk("R11 rts_n idle", rts_n, 1);
        chk("R11 dtr_n idle", dtr_n, 1);
        cts_n = 1'b1; dsr_n = 1'b0;
        read_reg(3'd6, v);
        chk("R11 status from ctl", v, 8'h10);
        dsr_n = 1'b1; ser_in = 1'b1;
        write_reg(3'd4, 8'h00);
    endtask

    task automatic t_break();
        tx_serial = 1'b1; ser_in = 1'b0;
        write_reg(3'd3, 8'h40);
        chk("R12 break low", ser_out, 0);
        chk("R12 rx from pin", rx_serial, 0);
        write_reg(3'd4, 8'h10);
        chk("R12 loop over break", ser_out, 1);
        write_reg(3'd4, 8'h00);
        write_reg(3'd3, 8'h00);
        chk("R12 break released", ser_out, 1);
        ser_in = 1'b1;
    endtask

    task automatic t_unused();
        logic [7:0] v;
        write_reg(3'd3, 8'h07);
        write_reg(3'd4, 8'h01);
        write_reg(3'd2, 8'hFF);
        write_reg(3'd5, 8'hFF);
        write_reg(3'd7, 8'hFF);
        read_reg(3'd2, v); chk("R13 ofs2 zero", v, 0);
        read_reg(3'd5, v); chk("R13 ofs5 zero", v, 0);
        read_reg(3'd7, v); chk("R13 ofs7 zero", v, 0);
        chk("R13 line kept", line_fmt, 8'h07);
        read_reg(3'd4, v); chk("R13 modem kept", v, 8'h01);
        chk("R13 ier kept", ier, 4'hF);
        write_reg(3'd3, 8'h00);
        write_reg(3'd4, 8'h00);
    endtask

    task automatic t_busy();
        @(negedge clk);
        addr = 3'd3; wdata = 8'h11; wr_en = 1'b1;
        @(negedge clk);
        wdata = 8'h22;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R2 busy strobe ignored", line_fmt, 8'h11);
        write_reg(3'd3, 8'h00);
        @(negedge clk);
        addr = 3'd0; wdata = 8'h5A; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R2 write wins load", tx_load, 1);
        chk("R2 write wins pop", rx_pop, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data();
        t_ier();
        t_bank();
        t_line();
        t_modem();
        t_irq();
        t_mstat();
        t_loop();
        t_break();
        t_unused();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule